// File: doc/BRIEF.md
# Sequenced Two-Bit Function Unit

This block is a tiny datapath that combines a fixed operand `a` with a stored operand held in an internal register. A two-bit select chooses one of four operations. Three of them work bit by bit: invert the stored operand, AND the two operands, or OR them. The fourth adds the two operands as unsigned numbers and reports the carry. The result is one bit wider than the operands. Its top bit is the carry, and it is forced to zero for every operation that is not the addition.

The stored operand makes it possible to chain operations one clock at a time. On each rising edge the register takes one of two values:
- with `load` high, the external operand `c_in`;
- with `load` low, the low bits of the current result.

A program of operations can therefore run step by step. At any step the chain can be broken by loading a fresh value. The carry bit is never fed back. The result is combinational from `a_in`, `sel` and the register contents. An active-high synchronous reset clears the register.

Top module: `chain_alu`

## Requirements
- R1: A synchronous active-high `rst` clears the stored operand to 0 on the next rising edge, and `rst` has priority over `load`.
- R2: With `sel` = 2'b11, `res_out[W-1:0]` is the bitwise inverse of the stored operand, `a_in` has no effect, and `res_out[W]` = 0.
- R3: With `sel` = 2'b10, `res_out[W-1:0]` is the bitwise AND of `a_in` and the stored operand, and `res_out[W]` = 0.
- R4: With `sel` = 2'b01, `res_out[W-1:0]` is the bitwise OR of `a_in` and the stored operand, and `res_out[W]` = 0.
- R5: With `sel` = 2'b00, `res_out` is the (W+1)-bit unsigned sum of `a_in` and the stored operand, with the carry in `res_out[W]`.
- R6: When `load` is high and `rst` is low, the stored operand takes `c_in` on the rising edge.
- R7: When `load` and `rst` are low, the stored operand takes `res_out[W-1:0]` of that cycle on the rising edge. The carry `res_out[W]` is never stored.
- R8: `res_out` follows changes of `a_in` and `sel` within the same cycle, without waiting for a clock edge.

Top module port list follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset of the stored operand |
| load | input | 1 | 1: store `c_in`; 0: store the low result bits |
| sel | input | 2 | Operation: 00 add, 01 OR, 10 AND, 11 invert |
| a_in | input | W | First operand (bit W-1 is the most significant) |
| c_in | input | W | External value for the stored operand |
| res_out | output | W+1 | Result; bit W is the carry, zero unless adding |

## Verification
Two cases can fall on the same edge, and the bench provokes both.

The first is an addition that produces a carry on an edge where feedback is selected. The bench chains an addition with carry into a feedback step and then reads the stored operand back through the invert operation. The value read back must equal the low sum bits only.

The second is reset and load on the same edge. The bench raises `rst` and `load` together with a nonzero `c_in`. It then reads the stored operand through the OR operation with `a_in` = 0 and expects 0.

Every step of the mixed load and feedback chains is also compared against a model of the register kept inside the bench.

// File: rtl/chain_alu_pkg.sv
package chain_alu_pkg;
  typedef enum logic [1:0] {
    FN_ADD = 2'b00,
    FN_OR  = 2'b01,
    FN_AND = 2'b10,
    FN_INV = 2'b11
  } fn_e;
endpackage

// File: rtl/chain_alu_logic.sv
module chain_alu_logic
  import chain_alu_pkg::*;
#(
  parameter int W = 2
) (
  input  fn_e          fn,
  input  logic [W-1:0] opa,
  input  logic [W-1:0] opb,
  output logic [W:0]   res
);
  logic [W-1:0] and_v, or_v, inv_v, sum_v;
  logic [W:0]   carry;

  assign carry[0] = 1'b0;

  // per-bit cells: bitwise ops and a ripple full adder
  for (genvar i = 0; i < W; i++) begin : g_bit
    assign and_v[i]     = opa[i] & opb[i];
    assign or_v[i]      = opa[i] | opb[i];
    assign inv_v[i]     = ~opb[i];
    assign sum_v[i]     = opa[i] ^ opb[i] ^ carry[i];
    assign carry[i+1]   = (opa[i] & opb[i]) | (carry[i] & (opa[i] ^ opb[i]));
  end

  always_comb begin
    unique case (fn)
      FN_ADD:  res = {carry[W], sum_v};
      FN_OR:   res = {1'b0, or_v};
      FN_AND:  res = {1'b0, and_v};
      default: res = {1'b0, inv_v};
    endcase
  end
endmodule

// File: rtl/chain_alu_opreg.sv
module chain_alu_opreg #(
  parameter int W = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] ext_val,
  input  logic [W-1:0] fb_val,
  output logic [W-1:0] cd_q
);
  always_ff @(posedge clk) begin
    if (rst)       cd_q <= '0;
    else if (load) cd_q <= ext_val;
    else           cd_q <= fb_val;
  end

  // R1: one edge after reset the register is zero, whatever load was
  logic rst_d;
  always_ff @(posedge clk) begin
    rst_d <= rst;
    if (rst_d == 1'b1) begin
      a_r1_reset_clears: assert (cd_q == '0);
    end
  end

  a_r6_load_captures: assert property (@(posedge clk) disable iff (rst)
    load |=> cd_q == $past(ext_val));

  a_r7_feedback_captures: assert property (@(posedge clk) disable iff (rst)
    !load |=> cd_q == $past(fb_val));
endmodule

// File: rtl/chain_alu.sv
module chain_alu
  import chain_alu_pkg::*;
#(
  parameter int W = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [1:0]   sel,
  input  logic [W-1:0] a_in,
  input  logic [W-1:0] c_in,
  output logic [W:0]   res_out
);
  localparam int RW = W + 1;

  fn_e          fn;
  logic [W-1:0] cd_q;
  logic [RW-1:0] res;

  assign fn      = fn_e'(sel);
  assign res_out = res;

  chain_alu_opreg #(.W(W)) u_opreg (
    .clk     (clk),
    .rst     (rst),
    .load    (load),
    .ext_val (c_in),
    .fb_val  (res[W-1:0]),
    .cd_q    (cd_q)
  );

  chain_alu_logic #(.W(W)) u_logic (
    .fn  (fn),
    .opa (a_in),
    .opb (cd_q),
    .res (res)
  );

  a_r2_invert: assert property (@(posedge clk) disable iff (rst)
    (sel == 2'b11) |-> ((res_out[W-1:0] ^ cd_q) == {W{1'b1}}) && !res_out[W]);

  a_r3_and: assert property (@(posedge clk) disable iff (rst)
    (sel == 2'b10) |-> ((res_out[W-1:0] & ~a_in) == '0) &&
                       ((res_out[W-1:0] & ~cd_q) == '0) && !res_out[W]);

  a_r4_or: assert property (@(posedge clk) disable iff (rst)
    (sel == 2'b01) |-> ((res_out[W-1:0] | a_in | cd_q) == res_out[W-1:0]) &&
                       ((a_in & ~res_out[W-1:0]) == '0) && !res_out[W]);

  a_r5_sum: assert property (@(posedge clk) disable iff (rst)
    (sel == 2'b00) |-> (RW'(res_out) - RW'(a_in)) == RW'(cd_q));
endmodule

// File: tb/chain_alu_tb.sv
module chain_alu_tb;
  localparam int W = 2;

  logic         clk = 1'b0;
  logic         rst, load;
  logic [1:0]   sel;
  logic [W-1:0] a_in, c_in;
  logic [W:0]   res_out;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;
  logic [W-1:0] model_cd;

  always #4 clk = ~clk;

  chain_alu #(.W(W)) u_dut (
    .clk(clk), .rst(rst), .load(load), .sel(sel),
    .a_in(a_in), .c_in(c_in), .res_out(res_out)
  );

  function automatic logic [W:0] ref_res(logic [1:0] s, logic [W-1:0] a, logic [W-1:0] cd);
    case (s)
      2'b00:   return {1'b0, a} + {1'b0, cd};
      2'b01:   return {1'b0, a | cd};
      2'b10:   return {1'b0, a & cd};
      default: return {1'b0, ~cd};
    endcase
  endfunction

  task automatic chk(string req, logic [W:0] got, logic [W:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %b expected %b", req, got, exp);
    end
  endtask

  // one clock step: drive after negedge, check, then clock the model
  task automatic step(string req, logic r, logic ld, logic [1:0] s,
                      logic [W-1:0] a, logic [W-1:0] c);
    logic [W:0] exp;
    @(negedge clk);
    rst = r; load = ld; sel = s; a_in = a; c_in = c;
    #1;
    exp = ref_res(s, a, model_cd);
    if (!r) chk(req, res_out, exp);
    @(posedge clk);
    if (r)       model_cd = '0;
    else if (ld) model_cd = c;
    else         model_cd = exp[W-1:0];
  endtask

  task automatic t_reset;
    step("R1", 1'b1, 1'b0, 2'b00, '0, '0);
    model_cd = '0;
    step("R1", 1'b0, 1'b1, 2'b01, '0, '0);
  endtask

  task automatic t_exhaustive(logic [1:0] s, string req);
    for (int cd = 0; cd < 4; cd++)
      for (int a = 0; a < 4; a++) begin
        step("R6", 1'b0, 1'b1, 2'b01, '0, W'(cd));
        step(req, 1'b0, 1'b1, s, W'(a), W'(cd));
      end
  endtask

  task automatic t_chain;
    step("R6", 1'b0, 1'b1, 2'b00, 2'd2, 2'd1);
    step("R5", 1'b0, 1'b0, 2'b00, 2'd2, 2'd0);  // 2+1=011, store 11
    step("R7", 1'b0, 1'b0, 2'b00, 2'd3, 2'd0);  // 3+3=110, carry dropped
    step("R7", 1'b0, 1'b0, 2'b11, 2'd0, 2'd0);  // reads ~10 = 01
    step("R7", 1'b0, 1'b0, 2'b01, 2'd2, 2'd0);  // 01|10 = 11
    step("R7", 1'b0, 1'b1, 2'b10, 2'd1, 2'd2);  // 11&01, then load 10
    step("R6", 1'b0, 1'b0, 2'b00, 2'd3, 2'd0);  // 3+2=101
    step("R7", 1'b0, 1'b0, 2'b11, 2'd3, 2'd0);  // ~01 = 10
    chk("R7", model_cd, 2'b10);
  endtask

  task automatic t_reset_vs_load;
    step("R1", 1'b1, 1'b1, 2'b00, '0, 2'd3);
    step("R1", 1'b0, 1'b0, 2'b01, '0, 2'd3);
  endtask

  task automatic t_comb;
    logic [W:0] e1;
    step("R6", 1'b0, 1'b1, 2'b00, 2'd0, 2'd1);
    @(negedge clk);
    load = 1'b1; c_in = 2'd1; sel = 2'b00; a_in = 2'd1;
    #1 chk("R8", res_out, 3'b010);
    a_in = 2'd3; #1 chk("R8", res_out, 3'b100);
    sel = 2'b11; #1 e1 = {1'b0, 2'b10}; chk("R8", res_out, e1);
    @(posedge clk);
    model_cd = 2'd1;
  endtask

  initial begin
    rst = 1'b1; load = 1'b0; sel = '0; a_in = '0; c_in = '0; model_cd = '0;
    t_reset();
    t_exhaustive(2'b11, "R2");
    t_exhaustive(2'b10, "R3");
    t_exhaustive(2'b01, "R4");
    t_exhaustive(2'b00, "R5");
    t_chain();
    t_reset_vs_load();
    t_comb();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule